// File: doc/BRIEF.md
# IPv4 Flow Bucket Hash

This block turns an IPv4 flow key into a bucket index for a flow table. The key has four parts: source address, destination address, source port and destination port. The block combines them with a fixed select, rotate and fold function. The result is an even 12-bit index between 0 and 4094. Each even bucket therefore has an odd companion slot, which the table logic can use as a second way.

Keys enter on a valid/ready stream. One registered stage holds the result, and the result leaves on a second valid/ready stream. The source may change or drop the key freely while `in_valid` is low. Once a key is presented with `in_valid` high, it is taken on the first clock edge where `in_ready` is also high. On the output side, a result that is shown while `out_ready` is low stays unchanged until the sink accepts it. `in_ready` is high whenever the stage is empty or the sink is taking the held result. This lets the block accept one key per clock when the sink is not stalling, and it applies back-pressure upstream as soon as the sink stalls.

Top module: `flowhash_top`

## Requirements
- R1: The port word is 32 bits wide, with the source port in bits 31:16 and the destination port in bits 15:0.
- R2: The mix word takes each bit from the destination address where the matching port-word bit is 1, and from the source address where it is 0.
- R3: The pre-fold word is the XOR of the port word, the destination address, the source address and the mix word rotated left by 8 bits.
- R4: The fold XORs the pre-fold word shifted right by 16 with its low 20 bits, zero-extended.
- R5: `out_idx` is 12 bits wide. Bits 11:1 hold the low 11 bits of the folded word, and bit 0 is always 0. For example, an all-zero key gives 0, destination port 1 with everything else zero gives 2, and source address 0x01000000 with everything else zero gives 0x202.
- R6: A key accepted on a clock edge appears on `out_valid`/`out_idx` right after that same edge, which is a latency of one clock.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_idx` holds its value.
- R8: `in_ready` is high exactly when the stage is empty or `out_ready` is high, so the block sustains one key per clock with no stall.
- R9: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R10: Key inputs presented with `in_valid` low produce no output item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Key on the inputs is valid |
| in_ready | output | 1 | Block can accept a key this cycle |
| in_saddr | input | 32 | Source IPv4 address, numeric order |
| in_daddr | input | 32 | Destination IPv4 address, numeric order |
| in_sport | input | 16 | Source L4 port |
| in_dport | input | 16 | Destination L4 port |
| out_valid | output | 1 | Bucket index is valid |
| out_ready | input | 1 | Sink accepts the index this cycle |
| out_idx | output | 12 | Even bucket index |

## Verification
An index is due one clock after its key is accepted. The bench records each key when it observes `in_valid` and `in_ready` both high at a falling edge. It then expects `out_valid` at the next falling edge. The scoreboard pops the oldest expected index at each falling edge where `out_valid` and `out_ready` are both high. When a stall is seen at one falling edge, the bench checks at the following falling edge that the held index has not changed. The `in_ready` value is compared every cycle against the current output-side state.

// File: rtl/flowhash_pkg.sv
package flowhash_pkg;
  localparam int ADDR_W = 32;
  localparam int PORT_W = 16;
  localparam int WORD_W = 2 * PORT_W;

  typedef struct packed {
    logic [ADDR_W-1:0] saddr;
    logic [ADDR_W-1:0] daddr;
    logic [PORT_W-1:0] sport;
    logic [PORT_W-1:0] dport;
  } flow_key_t;
endpackage

// File: rtl/flowhash_mix.sv
module flowhash_mix
  import flowhash_pkg::*;
(
  input  flow_key_t         key,
  output logic [WORD_W-1:0] port_word,
  output logic [WORD_W-1:0] mix_word
);
  // R1: source port high, destination port low
  assign port_word = {key.sport, key.dport};

  // R2: per-bit select between addresses
  for (genvar b = 0; b < WORD_W; b++) begin : g_sel
    assign mix_word[b] = port_word[b] ? key.daddr[b] : key.saddr[b];
  end
endmodule

// File: rtl/flowhash_fold.sv
module flowhash_fold
  import flowhash_pkg::*;
#(
  parameter int ROT_AMT    = 8,
  parameter int FOLD_SHIFT = 16,
  parameter int FOLD_KEEP  = 20,
  parameter int BKT_W      = 11,
  localparam int IDX_W     = BKT_W + 1
) (
  input  logic [WORD_W-1:0] port_word,
  input  logic [WORD_W-1:0] mix_word,
  input  logic [ADDR_W-1:0] saddr,
  input  logic [ADDR_W-1:0] daddr,
  output logic [IDX_W-1:0]  idx
);
  logic [WORD_W-1:0] rot_word;
  logic [WORD_W-1:0] pre_fold;
  logic [WORD_W-1:0] hi_part;
  logic [WORD_W-1:0] lo_part;
  logic [WORD_W-1:0] folded;

  // R3: rotate left, then four-way XOR
  assign rot_word = {mix_word[WORD_W-1-ROT_AMT:0], mix_word[WORD_W-1:WORD_W-ROT_AMT]};
  assign pre_fold = port_word ^ daddr ^ saddr ^ rot_word;

  // R4: fold upper half into low window
  assign hi_part = pre_fold >> FOLD_SHIFT;
  assign lo_part = {{(WORD_W-FOLD_KEEP){1'b0}}, pre_fold[FOLD_KEEP-1:0]};
  assign folded  = hi_part ^ lo_part;

  // R5: keep bucket bits, force even
  assign idx = {folded[BKT_W-1:0], 1'b0};
endmodule

// File: rtl/flowhash_stage.sv
module flowhash_stage #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end

  // R6
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R8
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R10
  idle_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !out_valid);
endmodule

// File: rtl/flowhash_top.sv
module flowhash_top
  import flowhash_pkg::*;
#(
  parameter int ROT_AMT    = 8,
  parameter int FOLD_SHIFT = 16,
  parameter int FOLD_KEEP  = 20,
  parameter int BKT_W      = 11,
  localparam int IDX_W     = BKT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_saddr,
  input  logic [ADDR_W-1:0] in_daddr,
  input  logic [PORT_W-1:0] in_sport,
  input  logic [PORT_W-1:0] in_dport,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_idx
);
  flow_key_t         key;
  logic [WORD_W-1:0] port_word;
  logic [WORD_W-1:0] mix_word;
  logic [IDX_W-1:0]  idx_comb;

  assign key = '{saddr: in_saddr, daddr: in_daddr, sport: in_sport, dport: in_dport};

  flowhash_mix mix_i (
    .key       (key),
    .port_word (port_word),
    .mix_word  (mix_word)
  );

  flowhash_fold #(
    .ROT_AMT    (ROT_AMT),
    .FOLD_SHIFT (FOLD_SHIFT),
    .FOLD_KEEP  (FOLD_KEEP),
    .BKT_W      (BKT_W)
  ) fold_i (
    .port_word (port_word),
    .mix_word  (mix_word),
    .saddr     (in_saddr),
    .daddr     (in_daddr),
    .idx       (idx_comb)
  );

  flowhash_stage #(.DATA_W(IDX_W)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (idx_comb),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_idx)
  );

  // R5
  even_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx[0] == 1'b0));
endmodule

// File: tb/flowhash_top_tb_top.sv
module flowhash_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_saddr = '0;
  logic [31:0] in_daddr = '0;
  logic [15:0] in_sport = '0;
  logic [15:0] in_dport = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_idx;

  int checks = 0;
  int failures = 0;
  bit stall_mode = 1'b0;
  bit hold_pend = 1'b0;
  bit acc_prev = 1'b0;
  logic [11:0] held;

  typedef struct {
    logic [11:0] idx;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  flowhash_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_saddr(in_saddr), .in_daddr(in_daddr), .in_sport(in_sport),
    .in_dport(in_dport), .out_valid(out_valid), .out_ready(out_ready),
    .out_idx(out_idx)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ref_hash(input logic [31:0] s, input logic [31:0] d,
                                           input logic [15:0] sp, input logic [15:0] dp);
    logic [31:0] pw, mx, rt, h, f;
    pw = {sp, dp};
    for (int b = 0; b < 32; b++) mx[b] = pw[b] ? d[b] : s[b];
    for (int b = 0; b < 32; b++) rt[(b + 8) % 32] = mx[b];
    h = pw ^ s ^ d ^ rt;
    f = (h >> 16) ^ (h & 32'h000f_ffff);
    return {f[10:0], 1'b0};
  endfunction

  task automatic send(input logic [31:0] s, input logic [31:0] d, input logic [15:0] sp,
                      input logic [15:0] dp, input logic [11:0] exp_idx, input string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_saddr = s; in_daddr = d; in_sport = sp; in_dport = dp;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        q.push_back('{idx: exp_idx, tag: tag});
        break;
      end
    end
  endtask

  task automatic send_ref(input logic [31:0] s, input logic [31:0] d, input logic [15:0] sp,
                          input logic [15:0] dp, input string tag);
    send(s, d, sp, dp, ref_hash(s, d, sp, dp), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_saddr = $urandom; in_daddr = $urandom;
      in_sport = 16'($urandom); in_dport = 16'($urandom);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (stall_mode) out_ready = ($urandom % 3) != 0;
    else out_ready = 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (acc_prev) check(out_valid, "R6 valid one clock after accept", {31'd0, out_valid}, 32'd1);
      acc_prev = in_valid && in_ready;
      if (hold_pend) begin
        check(out_valid && out_idx == held, "R7 stalled output held", {20'd0, out_idx}, {20'd0, held});
        hold_pend = 1'b0;
      end
      if (!out_valid || out_ready) check(in_ready, "R8 ready with room", {31'd0, in_ready}, 32'd1);
      else check(!in_ready, "R8 back-pressure", {31'd0, in_ready}, 32'd0);
      if (out_valid && !out_ready) begin
        held = out_idx;
        hold_pend = 1'b1;
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected output item", {20'd0, out_idx}, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(out_idx == e.idx, e.tag, {20'd0, out_idx}, {20'd0, e.idx});
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9
    check(!out_valid, "R9 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check(in_ready, "R9 in_ready in reset", {31'd0, in_ready}, 32'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R5 hand-computed values
    send(32'h0, 32'h0, 16'h0, 16'h0, 12'h000, "R5 all-zero key");
    send(32'h0, 32'h0, 16'h0, 16'h1, 12'h002, "R5 dport one");
    send(32'hffff_ffff, 32'hffff_ffff, 16'hffff, 16'hffff, 12'h000, "R5 all-ones key");
    // R3 R4 hand-computed rotate and fold
    send(32'h0100_0000, 32'h0, 16'h0, 16'h0, 12'h202, "R3 R4 rotate then fold");
    // R1 port placement
    send_ref(32'h0, 32'h0, 16'h1234, 16'h0, "R1 source port high half");
    send_ref(32'h0, 32'h0, 16'h0, 16'h1234, "R1 destination port low half");
    send_ref(32'h0, 32'h0, 16'h00a5, 16'h5a00, "R1 both ports");
    // R2 select
    send_ref(32'hdead_beef, 32'h1357_9bdf, 16'hffff, 16'hffff, "R2 all from daddr");
    send_ref(32'hdead_beef, 32'h1357_9bdf, 16'h0, 16'h0, "R2 all from saddr");
    send_ref(32'hdead_beef, 32'h1357_9bdf, 16'hff00, 16'h00ff, "R2 mixed select");
    // R4 high bits only
    send_ref(32'hf000_0000, 32'h0000_000f, 16'h8000, 16'h0001, "R4 upper bits fold");
    idle(5);
    @(negedge clk);
    // R10
    check(!out_valid, "R10 no output while idle", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < 300; i++)
      send_ref($urandom, $urandom, 16'($urandom), 16'($urandom), "R3 random key");
    idle(2);
    stall_mode = 1'b1;
    for (int i = 0; i < 300; i++) begin
      send_ref($urandom, $urandom, 16'($urandom), 16'($urandom), "R7 random key under stall");
      if (i % 7 == 0) idle(1);
    end
    idle(1);
    stall_mode = 1'b0;
    idle(10);
    @(negedge clk);
    check(q.size() == 0, "R6 all items delivered", q.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule